// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Control

This block is the hazard control of an in-order five-stage integer pipeline. It looks at the source register numbers held in the decode/execute latch. It compares them with the destination register numbers of the two older instructions, which sit in the execute/memory and memory/writeback latches. From this it produces one 2-bit select per ALU operand. The select tells the operand multiplexer to take the value from the register file, from the execute/memory latch or from the memory/writeback latch.

The block also watches for a load in the decode/execute latch whose result is needed by the instruction right behind it in the fetch/decode latch. The loaded word does not exist until the memory stage ends, so it cannot be forwarded in time. In that case the block raises three control lines together. Two of them hold the program counter and the fetch/decode latch. The third turns the decode/execute entry into a bubble: a no-op that writes neither registers nor memory.

All outputs are purely combinational functions of the register numbers, the write enables and the load flag. The block has no state.

Top module: `hazard_unit`

## Requirements
- R1: With no qualifying producer for a source, its select is 2'b00 (register file). The value 2'b11 is never produced.
- R2: When the execute/memory latch writes a register (`exmem_reg_write`=1) whose number is nonzero and equals the source, the select is 2'b01.
- R3: When the memory/writeback latch writes a nonzero register that equals the source, and R2 does not apply, the select is 2'b10.
- R4: A latch whose write enable is 0 never causes forwarding, whatever its register number.
- R5: A destination register number of 0 never causes forwarding, even with its write enable set.
- R6: When both later latches qualify for the same source, the execute/memory latch wins (2'b01).
- R7: `fwd_a` is decided by `idex_rs` alone and `fwd_b` by `idex_rt` alone. The two selects are independent of each other.
- R8: A load-use hazard exists when `idex_mem_read`=1, `idex_dst` is nonzero, and `idex_dst` equals `ifid_rs` or `ifid_rt`. During such a hazard, `stall_pc`, `stall_ifid` and `flush_idex` are all 1.
- R9: The three stall lines are always equal. They are 0 whenever `idex_mem_read`=0, `idex_dst`=0, or neither fetch/decode source matches `idex_dst`.
- R10: One cycle after the stall, the load has moved to execute/memory and the bubble (write enable 0) sits behind it. One more cycle later the load is in memory/writeback and the dependent instruction is in decode/execute. At that point the dependent operand's select is 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_rs | input | 5 | First source register of the instruction in fetch/decode |
| ifid_rt | input | 5 | Second source register of the instruction in fetch/decode |
| idex_rs | input | 5 | First source register of the instruction in decode/execute (operand A) |
| idex_rt | input | 5 | Second source register of the instruction in decode/execute (operand B) |
| idex_dst | input | 5 | Destination register of the instruction in decode/execute |
| idex_mem_read | input | 1 | Instruction in decode/execute is a load |
| exmem_rd | input | 5 | Destination register in execute/memory |
| exmem_reg_write | input | 1 | Execute/memory instruction writes a register |
| memwb_rd | input | 5 | Destination register in memory/writeback |
| memwb_reg_write | input | 1 | Memory/writeback instruction writes a register |
| stall_pc | output | 1 | Hold the program counter this cycle |
| stall_ifid | output | 1 | Hold the fetch/decode latch this cycle |
| flush_idex | output | 1 | Load a bubble into decode/execute this cycle |
| fwd_a | output | 2 | Operand A select: 00 register file, 01 execute/memory, 10 memory/writeback |
| fwd_b | output | 2 | Operand B select, same encoding |

## Verification
The assertions assume that every input is a defined value settled within the cycle. They also assume that a register number of 0 stands for the hard-wired zero register. They make no assumption about consistency between latches. For that reason the stimulus is free to show any mix of numbers and flags, including states that a real pipeline would never produce. Both the directed cases and the pseudo-random cases draw register numbers from a small range that includes 0. This makes matches, double matches and zero destinations frequent.

// File: rtl/hazard_pkg.sv
// Package hazard_pkg
// Shared encoding of the operand-source select used by the forwarding logic.
// Assumes the datapath multiplexer decodes exactly these three codes.
package hazard_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_EXMEM   = 2'b01,
        SRC_MEMWB   = 2'b10
    } src_sel_e;

endpackage

// File: rtl/fwd_select.sv
// Module fwd_select
// Chooses the source of one ALU operand by comparing its register number
// with the destinations of the two older in-flight instructions.
// Assumes register 0 is hard-wired to zero and is never a forwarding target.
module fwd_select #(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]    src,
    input  logic [ADDR_W-1:0]    exmem_rd,
    input  logic                 exmem_we,
    input  logic [ADDR_W-1:0]    memwb_rd,
    input  logic                 memwb_we,
    output hazard_pkg::src_sel_e sel
);
    import hazard_pkg::*;

    localparam logic [ADDR_W-1:0] ZERO_REG = '0;

    logic hit_exmem;
    logic hit_memwb;

    // Qualify each producer: it writes, it is not the zero register, it matches.
    always_comb begin
        hit_exmem = exmem_we && (exmem_rd != ZERO_REG) && (exmem_rd == src);
        hit_memwb = memwb_we && (memwb_rd != ZERO_REG) && (memwb_rd == src);
    end

    // Newest producer takes priority over the older one.
    always_comb begin
        if (hit_exmem)      sel = SRC_EXMEM;
        else if (hit_memwb) sel = SRC_MEMWB;
        else                sel = SRC_REGFILE;
    end

endmodule

// File: rtl/load_use_detect.sv
// Module load_use_detect
// Flags a load in decode/execute whose destination feeds either source
// of the instruction directly behind it in fetch/decode.
// Assumes the load's destination number is valid whenever load is set.
module load_use_detect #(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] ifid_rs,
    input  logic [ADDR_W-1:0] ifid_rt,
    input  logic [ADDR_W-1:0] load_dst,
    input  logic              load,
    output logic              hazard
);
    localparam logic [ADDR_W-1:0] ZERO_REG = '0;

    // A load into the zero register produces nothing worth waiting for.
    always_comb begin
        hazard = load && (load_dst != ZERO_REG) &&
                 ((load_dst == ifid_rs) || (load_dst == ifid_rt));
    end

endmodule

// File: rtl/hazard_unit.sv
// Module hazard_unit
// Hazard control for a five-stage in-order pipeline: two operand-forwarding
// selects plus a one-cycle load-use interlock. Purely combinational.
// Assumes the caller registers nothing here; all outputs settle within the cycle.
module hazard_unit #(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] ifid_rs,
    input  logic [ADDR_W-1:0] ifid_rt,
    input  logic [ADDR_W-1:0] idex_rs,
    input  logic [ADDR_W-1:0] idex_rt,
    input  logic [ADDR_W-1:0] idex_dst,
    input  logic              idex_mem_read,
    input  logic [ADDR_W-1:0] exmem_rd,
    input  logic              exmem_reg_write,
    input  logic [ADDR_W-1:0] memwb_rd,
    input  logic              memwb_reg_write,
    output logic              stall_pc,
    output logic              stall_ifid,
    output logic              flush_idex,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b
);
    import hazard_pkg::*;

    localparam int N_OPS = 2;

    logic [ADDR_W-1:0] op_src [N_OPS];
    src_sel_e          op_sel [N_OPS];
    logic              lu_hazard;

    // Gather operand sources: index 0 is A (rs), index 1 is B (rt).
    always_comb begin
        op_src[0] = idex_rs;
        op_src[1] = idex_rt;
    end

    // One forwarding selector per ALU operand.
    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        fwd_select #(.ADDR_W(ADDR_W)) u_sel (
            .src      (op_src[g]),
            .exmem_rd (exmem_rd),
            .exmem_we (exmem_reg_write),
            .memwb_rd (memwb_rd),
            .memwb_we (memwb_reg_write),
            .sel      (op_sel[g])
        );
    end

    load_use_detect #(.ADDR_W(ADDR_W)) u_lu (
        .ifid_rs  (ifid_rs),
        .ifid_rt  (ifid_rt),
        .load_dst (idex_dst),
        .load     (idex_mem_read),
        .hazard   (lu_hazard)
    );

    // Drive the select outputs and the three interlock lines.
    always_comb begin
        fwd_a      = op_sel[0];
        fwd_b      = op_sel[1];
        stall_pc   = lu_hazard;
        stall_ifid = lu_hazard;
        flush_idex = lu_hazard;
    end

endmodule

// File: rtl/hazard_unit_checker.sv
// Module hazard_unit_checker
// Immediate assertions on the combinational outputs of hazard_unit.
// Assumes inputs are two-state and settled whenever the block re-evaluates.
module hazard_unit_checker #(
    parameter int ADDR_W = 5
) (
    input logic [ADDR_W-1:0] ifid_rs,
    input logic [ADDR_W-1:0] ifid_rt,
    input logic [ADDR_W-1:0] idex_rs,
    input logic [ADDR_W-1:0] idex_rt,
    input logic [ADDR_W-1:0] idex_dst,
    input logic              idex_mem_read,
    input logic [ADDR_W-1:0] exmem_rd,
    input logic              exmem_reg_write,
    input logic [ADDR_W-1:0] memwb_rd,
    input logic              memwb_reg_write,
    input logic              stall_pc,
    input logic              stall_ifid,
    input logic              flush_idex,
    input logic [1:0]        fwd_a,
    input logic [1:0]        fwd_b
);
    // Check output relations against the inputs on every change.
    always_comb begin
        AST_CODE_LEGAL: assert (fwd_a != 2'b11 && fwd_b != 2'b11);                                  // R1
        AST_EXMEM_NEEDS_WRITE: assert (!(fwd_a == 2'b01 || fwd_b == 2'b01) || exmem_reg_write);     // R4
        AST_MEMWB_NEEDS_WRITE: assert (!(fwd_a == 2'b10 || fwd_b == 2'b10) || memwb_reg_write);     // R4
        AST_NO_ZERO_FWD_A: assert (fwd_a == 2'b00 || idex_rs != '0);                                // R5
        AST_NO_ZERO_FWD_B: assert (fwd_b == 2'b00 || idex_rt != '0);                                // R5
        AST_NEWEST_WINS: assert (!(exmem_reg_write && exmem_rd != '0 && exmem_rd == idex_rs) || fwd_a == 2'b01); // R6
        AST_STALL_AGREE: assert (stall_pc == stall_ifid && stall_ifid == flush_idex);               // R9
        AST_STALL_NEEDS_LOAD: assert (!stall_pc || (idex_mem_read && idex_dst != '0));             // R9
        AST_STALL_NEEDS_MATCH: assert (!stall_pc || idex_dst == ifid_rs || idex_dst == ifid_rt);    // R8
    end

endmodule

bind hazard_unit hazard_unit_checker #(.ADDR_W(ADDR_W)) u_hazard_unit_checker (.*);

// File: tb/hazard_unit_bench.sv
// Bench for hazard_unit: behavioural reference compared on every clock,
// plus directed hazard cases and a pipelined load-use walk.
module hazard_unit_bench;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    logic [4:0] ifid_rs, ifid_rt, idex_rs, idex_rt, idex_dst, exmem_rd, memwb_rd;
    logic       idex_mem_read, exmem_reg_write, memwb_reg_write;
    logic       stall_pc, stall_ifid, flush_idex;
    logic [1:0] fwd_a, fwd_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    hazard_unit u_hazard_unit (.*);

    // Reference: walk producers oldest to newest, the last qualifying one wins.
    function automatic logic [1:0] ref_sel(input logic [4:0] src);
        logic [4:0] rd [2];
        logic       we [2];
        logic [1:0] code [2];
        logic [1:0] res = 2'b00;
        rd[0] = memwb_rd; we[0] = memwb_reg_write; code[0] = 2'b10;
        rd[1] = exmem_rd; we[1] = exmem_reg_write; code[1] = 2'b01;
        for (int i = 0; i < 2; i++)
            if (we[i] && rd[i] != 0 && rd[i] == src) res = code[i];
        return res;
    endfunction

    function automatic logic ref_stall();
        if (!idex_mem_read || idex_dst == 0) return 1'b0;
        return (idex_dst == ifid_rs) || (idex_dst == ifid_rt);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "fwd_a", fwd_a, ref_sel(idex_rs));
        chk(tag, "fwd_b", fwd_b, ref_sel(idex_rt));
        chk(tag, "stall_pc", stall_pc, ref_stall());
        chk(tag, "stall_ifid", stall_ifid, ref_stall());
        chk(tag, "flush_idex", flush_idex, ref_stall());
    endtask

    // Apply one cycle of inputs after the edge, compare at the falling edge.
    task automatic step(input string tag,
                        input logic [4:0] frs, input logic [4:0] frt,
                        input logic [4:0] drs, input logic [4:0] drt,
                        input logic [4:0] ddst, input logic dld,
                        input logic [4:0] xrd, input logic xwe,
                        input logic [4:0] wrd, input logic wwe);
        @(posedge clk);
        #1;
        ifid_rs = frs; ifid_rt = frt; idex_rs = drs; idex_rt = drt;
        idex_dst = ddst; idex_mem_read = dld;
        exmem_rd = xrd; exmem_reg_write = xwe; memwb_rd = wrd; memwb_reg_write = wwe;
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: idle, all zero: register file, no stall
        step("R1", 0,0, 0,0, 0,0, 0,0, 0,0);
        chk("R1", "idle fwd_a", fwd_a, 0);
        chk("R9", "idle stall", stall_pc, 0);
        step("R1", 1,2, 3,4, 5,0, 6,1, 7,1);
        chk("R1", "no match fwd_b", fwd_b, 0);
        // R2: execute/memory match on A
        step("R2", 0,0, 3,4, 0,0, 3,1, 0,0);
        chk("R2", "fwd_a", fwd_a, 1);
        // R3: memory/writeback match on B
        step("R3", 0,0, 3,4, 0,0, 0,0, 4,1);
        chk("R3", "fwd_b", fwd_b, 2);
        // R4: write disabled
        step("R4", 0,0, 3,4, 0,0, 3,0, 4,0);
        chk("R4", "fwd_a", fwd_a, 0);
        chk("R4", "fwd_b", fwd_b, 0);
        // R5: zero destination with write enabled
        step("R5", 0,0, 0,0, 0,0, 0,1, 0,1);
        chk("R5", "fwd_a", fwd_a, 0);
        // R6: both producers match, newest wins
        step("R6", 0,0, 1,1, 0,0, 1,1, 1,1);
        chk("R6", "fwd_a", fwd_a, 1);
        chk("R6", "fwd_b", fwd_b, 1);
        // R6 with newer disabled: older wins
        step("R6", 0,0, 1,1, 0,0, 1,0, 1,1);
        chk("R6", "fwd_a older", fwd_a, 2);
        // R7: independent operands
        step("R7", 0,0, 5,6, 0,0, 6,1, 5,1);
        chk("R7", "fwd_a", fwd_a, 2);
        chk("R7", "fwd_b", fwd_b, 1);
        // R8: load-use on rt
        step("R8", 7,2, 0,0, 2,1, 0,0, 0,0);
        chk("R8", "flush_idex", flush_idex, 1);
        chk("R8", "stall_pc", stall_pc, 1);
        // R9: non-load, zero dest, mismatch
        step("R9", 2,2, 0,0, 2,0, 0,0, 0,0);
        chk("R9", "non-load", stall_ifid, 0);
        step("R9", 0,0, 0,0, 0,1, 0,0, 0,0);
        chk("R9", "zero dest load", stall_pc, 0);
        step("R9", 3,4, 0,0, 2,1, 0,0, 0,0);
        chk("R9", "mismatch", flush_idex, 0);
        // R10: load r2 followed by use of r2 in rs
        step("R10", 2,5, 1,0, 2,1, 0,0, 0,0);
        chk("R10", "stall", stall_pc, 1);
        step("R10", 2,5, 0,0, 0,0, 2,1, 0,0);
        chk("R10", "bubble cycle stall", stall_pc, 0);
        step("R10", 9,9, 2,5, 4,0, 0,0, 2,1);
        chk("R10", "fwd_a after stall", fwd_a, 2);
        // Pseudo-random sweep with a small register range
        for (int n = 0; n < 400; n++) begin
            step("R6", 5'($urandom_range(0,3)), 5'($urandom_range(0,3)),
                 5'($urandom_range(0,3)), 5'($urandom_range(0,3)),
                 5'($urandom_range(0,3)), 1'($urandom_range(0,1)),
                 5'($urandom_range(0,3)), 1'($urandom_range(0,1)),
                 5'($urandom_range(0,3)), 1'($urandom_range(0,1)));
        end
        finish_run();
    end

endmodule